// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block keeps the configuration-header registers of a PCI-to-PCI bridge that define which addresses the bridge forwards downstream. Software programs them through a dword-addressed configuration port with byte enables. From these registers the block derives three address windows: an I/O window, a non-prefetchable memory window and a prefetchable memory window. Each window has a base and a limit.

A lookup port takes an address and a space selector. One cycle later it reports whether the selected window claims that address. Any write that touches window register bytes raises a single-cycle remap pulse, so the surrounding logic can refresh its routing.

The bridge identity fields are fixed by parameters and read back as constants. These are the vendor and device IDs, the status capabilities, the class code and the header type. Two parameters select whether the I/O window decodes 32 address bits and whether the prefetchable window decodes 64 address bits.

Top module: `pcib_window_decoder`

## Requirements
- R1: After reset, the configuration dwords read back as follows. Dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 1 reads 0x00A00000, which is status 0x00A0 (66 MHz capable at bit 5, fast back-to-back capable at bit 7). Dword 2 reads 0x06040000, the PCI-to-PCI bridge class. Dword 3 has byte 2 equal to {MULTI_FN, 7'h01}. Bytes 2..3 of dword 7 read 0x00A0 as the secondary status. All window fields read zero.
- R2: Byte 0x1C bits 7:4 set I/O base address bits 15:12, with the low 12 bits zero. Byte 0x1D bits 7:4 set I/O limit bits 15:12, with the low 12 bits forced to 0xFFF. The low nibble of both bytes is read-only and reads 1 when IO_DEC32=1, and 0 otherwise.
- R3: When IO_DEC32=1, the 16-bit fields at bytes 0x30 (base) and 0x32 (limit) supply I/O address bits 31:16. When IO_DEC32=0, those bits are zero whatever is stored.
- R4: For the memory window, word 0x20 bits 15:4 give base address bits 31:20 and word 0x22 bits 15:4 give limit bits 31:20. The limit's low 20 bits are forced to 0xFFFFF. The low nibble of each word is read-only zero.
- R5: The prefetchable window decodes like R4 from words 0x24 (base) and 0x26 (limit). When PREF_DEC64=1, the dwords at 0x28 (base) and 0x2C (limit) supply address bits 63:32; otherwise those bits are zero. The low nibble of words 0x24 and 0x26 is read-only and reads 1 when PREF_DEC64=1, and 0 otherwise.
- R6: The lookup space selector lk_space uses bit 0 for I/O and bit 1 for prefetchable. With bit 0 set, the I/O window is used regardless of bit 1. With only bit 1 set, the prefetchable window is used. With neither bit set, the memory window is used.
- R7: A window claims an address only when limit >= base and base <= address <= limit, with both ends inclusive. A window whose base exceeds its limit claims nothing.
- R8: remap is high for exactly the cycle after a write that has an enabled byte in 0x1C..0x1D or 0x20..0x33. It stays low for every other write, including writes with no byte enables and writes to bytes 0x1E..0x1F.
- R9: lk_hit reflects the lookup presented in the previous cycle and is low when lk_valid was low. A write is already reflected by a lookup presented in the cycle after the write.
- R10: Writes to read-only bytes, to undefined dwords and to disabled byte lanes change no readback value and no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| remap | output | 1 | One-cycle pulse after a window register write |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Lookup address |
| lk_space | input | 2 | Bit 0 I/O, bit 1 prefetchable |
| lk_hit | output | 1 | Registered window hit |

## Verification
Two instances run side by side, one decoding 32-bit I/O and 64-bit prefetchable addresses and one decoding neither. The same register image therefore has to produce differing windows, which exposes whether the upper-address fields are applied or ignored. Lookups are aimed at each window's base, base minus one, limit and limit plus one, plus fully random addresses. This separates an off-by-one bound, a missing granule pad and a disabled window. Random writes with random byte enables over defined, read-only and undefined dwords show whether remap and storage obey lane masks. Directed cases cover space-selector priority and lookups without lk_valid.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam int ADDR_W  = 64;
  localparam int CFG_AW  = 4;

  localparam logic [CFG_AW-1:0] DW_ID    = 4'd0;
  localparam logic [CFG_AW-1:0] DW_CMD   = 4'd1;
  localparam logic [CFG_AW-1:0] DW_CLASS = 4'd2;
  localparam logic [CFG_AW-1:0] DW_HDR   = 4'd3;
  localparam logic [CFG_AW-1:0] DW_IO    = 4'd7;
  localparam logic [CFG_AW-1:0] DW_MEM   = 4'd8;
  localparam logic [CFG_AW-1:0] DW_PF    = 4'd9;
  localparam logic [CFG_AW-1:0] DW_PFUB  = 4'd10;
  localparam logic [CFG_AW-1:0] DW_PFUL  = 4'd11;
  localparam logic [CFG_AW-1:0] DW_IOU   = 4'd12;

  localparam logic [15:0] STAT_CAPS   = 16'h00A0;
  localparam logic [23:0] CLASS_P2P   = 24'h060400;

  localparam int WIN_IO  = 0;
  localparam int WIN_MEM = 1;
  localparam int WIN_PF  = 2;
  localparam int N_WIN   = 3;

  typedef struct packed {
    logic [3:0]  io_base_hi;
    logic [3:0]  io_lim_hi;
    logic [11:0] mem_base;
    logic [11:0] mem_lim;
    logic [11:0] pf_base;
    logic [11:0] pf_lim;
    logic [31:0] pf_ubase;
    logic [31:0] pf_ulim;
    logic [15:0] io_ubase;
    logic [15:0] io_ulim;
  } win_regs_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] lim;
  } window_t;
endpackage

// File: rtl/pcib_cfg_regs.sv
module pcib_cfg_regs
  import pcib_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h0A11,
  parameter bit          IO_DEC32   = 1'b1,
  parameter bit          PREF_DEC64 = 1'b1,
  parameter bit          MULTI_FN   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CFG_AW-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output win_regs_t         regs,
  output logic              remap
);
  localparam logic [3:0] IO_TYPE = IO_DEC32   ? 4'h1 : 4'h0;
  localparam logic [3:0] PF_TYPE = PREF_DEC64 ? 4'h1 : 4'h0;

  win_regs_t cur_q, nxt;
  logic      touch, remap_q;

  always_comb begin
    nxt = cur_q;
    unique case (addr)
      DW_IO: begin
        if (be[0]) nxt.io_base_hi = wdata[7:4];
        if (be[1]) nxt.io_lim_hi  = wdata[15:12];
      end
      DW_MEM: begin
        if (be[0]) nxt.mem_base[3:0]  = wdata[7:4];
        if (be[1]) nxt.mem_base[11:4] = wdata[15:8];
        if (be[2]) nxt.mem_lim[3:0]   = wdata[23:20];
        if (be[3]) nxt.mem_lim[11:4]  = wdata[31:24];
      end
      DW_PF: begin
        if (be[0]) nxt.pf_base[3:0]  = wdata[7:4];
        if (be[1]) nxt.pf_base[11:4] = wdata[15:8];
        if (be[2]) nxt.pf_lim[3:0]   = wdata[23:20];
        if (be[3]) nxt.pf_lim[11:4]  = wdata[31:24];
      end
      DW_PFUB: for (int i = 0; i < 4; i++) if (be[i]) nxt.pf_ubase[8*i +: 8] = wdata[8*i +: 8];
      DW_PFUL: for (int i = 0; i < 4; i++) if (be[i]) nxt.pf_ulim[8*i +: 8]  = wdata[8*i +: 8];
      DW_IOU: begin
        if (be[0]) nxt.io_ubase[7:0]  = wdata[7:0];
        if (be[1]) nxt.io_ubase[15:8] = wdata[15:8];
        if (be[2]) nxt.io_ulim[7:0]   = wdata[23:16];
        if (be[3]) nxt.io_ulim[15:8]  = wdata[31:24];
      end
      default: ;
    endcase
  end

  // window bytes: 0x1C..0x1D (dword 7 lanes 0..1) and 0x20..0x33 (dwords 8..12)
  always_comb begin
    touch = 1'b0;
    if (wr) begin
      if (addr == DW_IO) touch = |be[1:0];
      else if (addr >= DW_MEM && addr <= DW_IOU) touch = |be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      remap_q <= 1'b0;
    end else begin
      if (wr) cur_q <= nxt;
      remap_q <= touch;
    end
  end

  always_comb begin
    unique case (addr)
      DW_ID:    rdata = {DEVICE_ID, VENDOR_ID};
      DW_CMD:   rdata = {STAT_CAPS, 16'h0000};
      DW_CLASS: rdata = {CLASS_P2P, 8'h00};
      DW_HDR:   rdata = {8'h00, MULTI_FN, 7'h01, 16'h0000};
      DW_IO:    rdata = {STAT_CAPS, cur_q.io_lim_hi, IO_TYPE, cur_q.io_base_hi, IO_TYPE};
      DW_MEM:   rdata = {cur_q.mem_lim, 4'h0, cur_q.mem_base, 4'h0};
      DW_PF:    rdata = {cur_q.pf_lim, PF_TYPE, cur_q.pf_base, PF_TYPE};
      DW_PFUB:  rdata = cur_q.pf_ubase;
      DW_PFUL:  rdata = cur_q.pf_ulim;
      DW_IOU:   rdata = {cur_q.io_ulim, cur_q.io_ubase};
      default:  rdata = 32'h0;
    endcase
  end

  assign regs  = cur_q;
  assign remap = remap_q;
endmodule

// File: rtl/pcib_win_bounds.sv
module pcib_win_bounds
  import pcib_pkg::*;
#(
  parameter bit IO_DEC32   = 1'b1,
  parameter bit PREF_DEC64 = 1'b1
) (
  input  win_regs_t regs,
  output window_t   io_w,
  output window_t   mem_w,
  output window_t   pf_w
);
  logic [15:0] io_ub, io_ul;
  logic [31:0] pf_ub, pf_ul;

  generate
    if (IO_DEC32) begin : g_io32
      assign io_ub = regs.io_ubase;
      assign io_ul = regs.io_ulim;
    end else begin : g_io16
      assign io_ub = '0;
      assign io_ul = '0;
    end
    if (PREF_DEC64) begin : g_pf64
      assign pf_ub = regs.pf_ubase;
      assign pf_ul = regs.pf_ulim;
    end else begin : g_pf32
      assign pf_ub = '0;
      assign pf_ul = '0;
    end
  endgenerate

  assign io_w.base  = {32'h0, io_ub, regs.io_base_hi, 12'h000};
  assign io_w.lim   = {32'h0, io_ul, regs.io_lim_hi,  12'hFFF};
  assign mem_w.base = {32'h0, regs.mem_base, 20'h00000};
  assign mem_w.lim  = {32'h0, regs.mem_lim,  20'hFFFFF};
  assign pf_w.base  = {pf_ub, regs.pf_base, 20'h00000};
  assign pf_w.lim   = {pf_ul, regs.pf_lim,  20'hFFFFF};
endmodule

// File: rtl/pcib_win_cmp.sv
module pcib_win_cmp
  import pcib_pkg::*;
(
  input  window_t           win,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic enabled, above, below;
  assign enabled = win.lim >= win.base;
  assign above   = addr >= win.base;
  assign below   = addr <= win.lim;
  assign hit     = enabled & above & below;
endmodule

// File: rtl/pcib_window_decoder.sv
module pcib_window_decoder
  import pcib_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h0A11,
  parameter bit          IO_DEC32   = 1'b1,
  parameter bit          PREF_DEC64 = 1'b1,
  parameter bit          MULTI_FN   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        remap,
  input  logic        lk_valid,
  input  logic [63:0] lk_addr,
  input  logic [1:0]  lk_space,
  output logic        lk_hit
);
  logic [1:0] rst_sync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  win_regs_t regs;
  window_t   win [N_WIN];
  logic [N_WIN-1:0] hit_v;

  pcib_cfg_regs #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .IO_DEC32(IO_DEC32), .PREF_DEC64(PREF_DEC64), .MULTI_FN(MULTI_FN)
  ) u_regs (
    .clk(clk), .rst_n(rst_int), .wr(cfg_wr), .addr(cfg_addr), .be(cfg_be),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .regs(regs), .remap(remap)
  );

  pcib_win_bounds #(.IO_DEC32(IO_DEC32), .PREF_DEC64(PREF_DEC64)) u_bounds (
    .regs(regs), .io_w(win[WIN_IO]), .mem_w(win[WIN_MEM]), .pf_w(win[WIN_PF])
  );

  generate
    for (genvar g = 0; g < N_WIN; g++) begin : g_cmp
      pcib_win_cmp u_cmp (.win(win[g]), .addr(lk_addr), .hit(hit_v[g]));
    end
  endgenerate

  logic [1:0]        sel;
  logic [ADDR_W-1:0] sel_base, sel_lim;
  logic              hit_d, hit_q;

  always_comb begin
    if (lk_space[0])      sel = 2'(WIN_IO);
    else if (lk_space[1]) sel = 2'(WIN_PF);
    else                  sel = 2'(WIN_MEM);
    sel_base = win[sel].base;
    sel_lim  = win[sel].lim;
    hit_d    = lk_valid & hit_v[sel];
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) hit_q <= 1'b0;
    else          hit_q <= hit_d;
  end

  assign lk_hit = hit_q;
endmodule

// File: rtl/pcib_window_checker.sv
module pcib_window_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [3:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        remap,
  input logic        lk_valid,
  input logic        lk_hit,
  input logic [63:0] sel_base,
  input logic [63:0] sel_lim
);
  // R8: a remap pulse always follows a write
  a_r8_remap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    remap |-> $past(cfg_wr));

  // R9: a hit needs a lookup request in the previous cycle
  a_r9_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid));

  // R7: only an enabled window (limit >= base) can produce a hit
  a_r7_hit_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(sel_lim >= sel_base));

  // R10: without a write the readback of a held address does not change
  a_r10_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> (cfg_addr != $past(cfg_addr)) || $stable(cfg_rdata));
endmodule

bind pcib_window_decoder pcib_window_checker u_chk (
  .clk(clk), .rst_n(rst_int), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .remap(remap), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .sel_base(sel_base), .sel_lim(sel_lim)
);

// File: tb/tb_pcib_window_decoder.sv
module tb_pcib_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_addr = '0;
  logic [1:0]  lk_space = '0;
  logic [31:0] rd_a, rd_b;
  logic        rm_a, rm_b, hit_a, hit_b;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] sh [64];

  always #2 clk = ~clk;

  pcib_window_decoder #(.IO_DEC32(1'b1), .PREF_DEC64(1'b1), .MULTI_FN(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a), .remap(rm_a), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_space(lk_space), .lk_hit(hit_a));

  pcib_window_decoder #(.IO_DEC32(1'b0), .PREF_DEC64(1'b0), .MULTI_FN(1'b1)) dut2 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b), .remap(rm_b), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_space(lk_space), .lk_hit(hit_b));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // writable bits of each byte (R2, R4, R5 read-only nibbles, R10)
  function automatic logic [7:0] wmask(input int a);
    if (a == 'h1C || a == 'h1D || a == 'h20 || a == 'h22 || a == 'h24 || a == 'h26) return 8'hF0;
    if ((a >= 'h21 && a <= 'h33)) return 8'hFF;
    return 8'h00;
  endfunction

  // full=1: 32-bit I/O and 64-bit prefetchable, multifunction 0
  function automatic logic [7:0] exp_byte(input int a, input bit full);
    logic [7:0] t;
    t = full ? 8'h01 : 8'h00;
    case (a)
      0: return 8'hDE;  1: return 8'hC0;  2: return 8'h11;  3: return 8'h0A;
      6: return 8'hA0;  'hA: return 8'h04; 'hB: return 8'h06;
      'hE: return {~full, 7'h01};
      'h1C, 'h1D, 'h24, 'h26: return sh[a] | t;
      'h1E: return 8'hA0;
      default: return (a >= 'h20 && a <= 'h33) ? sh[a] : 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int dw, input bit full);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = exp_byte(dw*4 + i, full);
    return r;
  endfunction

  // returns {base, limit} of window: 0 io, 1 mem, 2 pf
  function automatic logic [127:0] bounds(input int w, input bit full);
    logic [63:0] b, l;
    case (w)
      0: begin
        b = {32'h0, full ? {sh['h31], sh['h30]} : 16'h0, sh['h1C][7:4], 12'h000};
        l = {32'h0, full ? {sh['h33], sh['h32]} : 16'h0, sh['h1D][7:4], 12'hFFF};
      end
      1: begin
        b = {32'h0, sh['h21], sh['h20][7:4], 20'h00000};
        l = {32'h0, sh['h23], sh['h22][7:4], 20'hFFFFF};
      end
      default: begin
        b = {full ? {sh['h2B], sh['h2A], sh['h29], sh['h28]} : 32'h0, sh['h25], sh['h24][7:4], 20'h00000};
        l = {full ? {sh['h2F], sh['h2E], sh['h2D], sh['h2C]} : 32'h0, sh['h27], sh['h26][7:4], 20'hFFFFF};
      end
    endcase
    return {b, l};
  endfunction

  function automatic int win_of(input logic [1:0] sp);
    return sp[0] ? 0 : (sp[1] ? 2 : 1);   // R6
  endfunction

  function automatic bit exp_hit(input logic [63:0] a, input logic [1:0] sp, input bit full);
    logic [127:0] bl;
    bl = bounds(win_of(sp), full);
    return (bl[63:0] >= bl[127:64]) && (a >= bl[127:64]) && (a <= bl[63:0]);  // R7
  endfunction

  task automatic wr_cfg(input logic [3:0] dw, input logic [3:0] be, input logic [31:0] d);
    bit er;
    er = 0;
    @(negedge clk);
    cfg_wr = 1; cfg_addr = dw; cfg_be = be; cfg_wdata = d;
    for (int i = 0; i < 4; i++) begin
      int a;
      a = int'(dw) * 4 + i;
      if (be[i]) begin
        sh[a] = (sh[a] & ~wmask(a)) | (d[8*i +: 8] & wmask(a));
        if ((a >= 'h1C && a <= 'h1D) || (a >= 'h20 && a <= 'h33)) er = 1;
      end
    end
    @(negedge clk);
    chk(rm_a == er, "R8 remap dut", 64'(rm_a), 64'(er));
    chk(rm_b == er, "R8 remap dut2", 64'(rm_b), 64'(er));
    cfg_wr = 0;
  endtask

  task automatic look(input logic [63:0] a, input logic [1:0] sp, input string req);
    bit ea, eb;
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_space = sp;
    ea = exp_hit(a, sp, 1'b1);
    eb = exp_hit(a, sp, 1'b0);
    @(negedge clk);
    chk(hit_a == ea, {req, " hit dut"}, 64'(hit_a), 64'(ea));
    chk(hit_b == eb, {req, " hit dut2"}, 64'(hit_b), 64'(eb));
    lk_valid = 0;
  endtask

  task automatic rd_chk(input logic [3:0] dw, input string req);
    @(negedge clk);
    cfg_addr = dw;
    #1;
    chk(rd_a == exp_rd(int'(dw), 1'b1), {req, " read dut"}, 64'(rd_a), 64'(exp_rd(int'(dw), 1'b1)));
    chk(rd_b == exp_rd(int'(dw), 1'b0), {req, " read dut2"}, 64'(rd_b), 64'(exp_rd(int'(dw), 1'b0)));
  endtask

  function automatic logic [63:0] pick_addr(input logic [1:0] sp);
    logic [127:0] bl;
    bl = bounds(win_of(sp), 1'b1);
    case ($urandom_range(0, 4))
      0: return bl[127:64];
      1: return bl[127:64] - 64'd1;
      2: return bl[63:0];
      3: return bl[63:0] + 64'd1;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) sh[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset readback, R2/R4/R5 type nibbles
    for (int d = 0; d < 16; d++) rd_chk(4'(d), "R1");
    @(negedge clk);
    chk(rm_a == 0 && rm_b == 0, "R8 remap idle after reset", 64'(rm_a), 0);

    // R2/R3 I/O window, with and without upper 16 bits
    wr_cfg(4'd7, 4'b0011, 32'hFFFF_4F2F);
    wr_cfg(4'd12, 4'b1111, 32'h0001_0001);
    rd_chk(4'd7, "R2");
    look(64'h0001_2000, 2'b00, "R3");
    look(64'h0000_2000, 2'b00, "R3");
    look(64'h0001_4FFF, 2'b00, "R2");
    look(64'h0001_5000, 2'b00, "R2");
    look(64'h0001_1FFF, 2'b00, "R2");
    // R9 no lookup, no hit
    @(negedge clk); lk_valid = 0; lk_addr = 64'h0001_2000; lk_space = 2'b00;
    @(negedge clk);
    chk(hit_a == 0, "R9 idle hit dut", 64'(hit_a), 0);
    // R6 I/O priority over prefetch bit
    look(64'h0001_3000, 2'b11, "R6");

    // R4 memory window
    wr_cfg(4'd8, 4'b1111, 32'hFE0F_FE01);
    look(64'hFE00_0000, 2'b00 | 2'b00, "R4");
    look(64'hFE0F_FFFF, 2'b00, "R4");
    look(64'hFE10_0000, 2'b00, "R4");
    look(64'hFDFF_FFFF, 2'b00, "R4");
    rd_chk(4'd8, "R4");

    // R5 prefetchable window with upper 32
    wr_cfg(4'd9, 4'b1111, 32'h8030_8010);
    wr_cfg(4'd10, 4'b1111, 32'h0000_0002);
    wr_cfg(4'd11, 4'b1111, 32'h0000_0002);
    look(64'h2_8010_0000, 2'b10, "R5");
    look(64'h0_8010_0000, 2'b10, "R5");
    look(64'h2_8030_0000, 2'b10, "R5");
    look(64'h2_8030_0000, 2'b01, "R6");
    rd_chk(4'd9, "R5");

    // R7 disabled window: base above limit
    wr_cfg(4'd8, 4'b1111, 32'hA000_B000);
    look(64'hA000_0000, 2'b00, "R7");
    look(64'hB000_0000, 2'b00, "R7");

    // R8/R10 non-window writes
    wr_cfg(4'd8, 4'b0000, 32'h1234_5678);
    wr_cfg(4'd7, 4'b1100, 32'hFFFF_0000);
    wr_cfg(4'd13, 4'b1111, 32'hFFFF_FFFF);
    wr_cfg(4'd0, 4'b1111, 32'h0);
    rd_chk(4'd0, "R10"); rd_chk(4'd7, "R10"); rd_chk(4'd13, "R10"); rd_chk(4'd8, "R10");

    // random mix
    for (int n = 0; n < 600; n++) begin
      case ($urandom_range(0, 2))
        0: wr_cfg(4'($urandom_range(0, 15)), 4'($urandom()), $urandom());
        1: rd_chk(4'($urandom_range(0, 15)), "R10");
        default: begin
          logic [1:0] sp;
          sp = 2'($urandom());
          look(pick_addr(sp), sp, "R7");
        end
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule